// File: doc/BRIEF.md
# Configuration-Image World Wide Name Extractor

This block holds a 128-byte configuration image and walks its chain of resource tags to find the 64-bit World Wide Name (WWN) that was programmed at manufacture. Software or a loader first fills the image through a byte write port. It then pulses `start`. The walker reads one byte per cycle. It hops over tags by their encoded lengths and descends only into the keyword-list tag, where it walks the keyword sub-fields in search of the WWN entry.

At the end of the scan the block raises `done`. It presents the eight WWN bytes, the image offset of the first WWN byte, and a `found` flag. An offset of zero means that no WWN was located. The results hold until the next start. Any byte the walker would need at or beyond the end of the image ends the scan, so a corrupt length field can never send a read outside the buffer.

Top module: `wwn_tag_scanner`

## Requirements
- R1: A `start` pulse while idle or done raises `busy` on the next cycle with `done` low, and the scan begins at offset 0. When the scan ends, `done` is 1 and `busy` is 0, and the results hold until the next accepted `start`.
- R2: A byte with bit 7 at 0 is a short tag. Its name is bits 6:3, and the walk advances by 1 plus bits 2:0. The short-tag name 4'hF ends the scan.
- R3: A byte with bit 7 at 1 is a long tag. Its name is bits 6:0 and its span is 3 plus the little-endian 16-bit value in the next two bytes (low byte first). A long tag whose name is not 7'h0D is passed over by its span without examining its contents.
- R4: Inside a long tag named 7'h0D, sub-fields start 3 bytes after the tag byte. Each sub-field's name is the low 6 bits of its first byte. Each step advances by 3 plus the little-endian 16-bit length held in the sub-field's next two bytes. The sub-field walk stops at the tag's span end, and the main walk then resumes at that span end.
- R5: If the byte 3 positions after a 7'h0D tag byte equals 8'h3B, no sub-fields are walked and the main walk advances by 6 from the tag byte.
- R6: A sub-field named 6'h3C carries the WWN in the 8 bytes after its 3-byte header. The first of those bytes lands in `wwn[63:56]` and the last in `wwn[7:0]`. `wwn_offset` is the image address of the first WWN byte, and `found` is 1.
- R7: The scan ends when the walk position reaches 128, or when any byte it needs lies at or beyond address 128. A WWN sub-field whose 8 bytes would not all fit below 128 is not captured.
- R8: Each accepted `start` clears `found`, `wwn_offset` and `wwn` to 0. A scan that locates no WWN ends with all three at 0.
- R9: When several WWN sub-fields are found during one scan, the last one visited supplies the results.
- R10: Writes presented while `busy` is 1 are dropped and leave the image unchanged.
- R11: While not busy, `wr_en` stores `wr_data` at image address `wr_addr` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Image byte write strobe |
| wr_addr | input | 7 | Image byte address |
| wr_data | input | 8 | Image byte value |
| start | input | 1 | Begin a scan (single-cycle pulse) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, results valid |
| found | output | 1 | A WWN was located |
| wwn_offset | output | 7 | Address of the first WWN byte, 0 if none |
| wwn | output | 64 | WWN, first image byte most significant |

## Verification
Directed images are used first to separate the individual rules:
- A bare keyword tag, and the same tag placed behind short tags, test the basic descent and the short-tag step.
- An end tag placed ahead of a valid WWN confirms that the scan stops there.
- A marker case is built so that honouring the marker lands on a WWN while following the tag's declared span would skip it.
- A foreign long tag whose body imitates a keyword tag shows that such tags are skipped blind.
- A pair of images puts the WWN exactly at the last offset that fits and one byte later, which pins the bounds guard.
- An all-zero image walks to the end on one-byte tags.
- A double-WWN image shows which match wins.

A write issued mid-scan is followed by a rescan, which proves that the write was dropped. Randomly assembled images then mix all tag kinds, random sub-field name upper bits and random filler, and every result is compared against a walk computed in the bench.

// File: rtl/wwn_scan_pkg.sv
package wwn_scan_pkg;

    // Walk positions must cover image end + 3 + a full 16-bit length.
    localparam int PW = 18;
    typedef logic [PW-1:0] ptr_t;

    localparam logic [3:0] SHORT_END_NAME = 4'hF;
    localparam logic [6:0] KEYLIST_NAME   = 7'h0D;
    localparam logic [7:0] KEYLIST_MARKER = 8'h3B;
    localparam logic [5:0] WWN_KEY_NAME   = 6'h3C;
    localparam int         HDR_BYTES      = 3;

    typedef enum logic [3:0] {
        WK_IDLE,
        WK_TAG,
        WK_LEN_LO,
        WK_LEN_HI,
        WK_MARK,
        WK_SUB,
        WK_SLEN_LO,
        WK_SLEN_HI,
        WK_COPY,
        WK_DONE
    } walk_state_t;

    typedef struct packed {
        logic       is_long;
        logic [6:0] name;
        logic [3:0] short_span;
    } tag_info_t;

    function automatic tag_info_t decode_tag(input logic [7:0] b);
        tag_info_t t;
        t.is_long    = b[7];
        t.name       = b[7] ? b[6:0] : {3'b000, b[6:3]};
        t.short_span = {1'b0, b[2:0]} + 4'd1;
        return t;
    endfunction

    // Position after a header of HDR_BYTES plus a little-endian 16-bit length.
    function automatic ptr_t span_end(input ptr_t base, input logic [7:0] lo,
                                      input logic [7:0] hi);
        return base + ptr_t'(HDR_BYTES) + ptr_t'({hi, lo});
    endfunction

endpackage

// File: rtl/vpd_image_store.sv
module vpd_image_store
    import wwn_scan_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  ptr_t          rd_addr,
    output logic          rd_ok,
    output logic [7:0]    rd_data
);
    localparam ptr_t LIMIT = ptr_t'(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (ptr_t'(wr_addr) < LIMIT)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_ok   = (rd_addr < LIMIT);
    assign rd_data = rd_ok ? mem[rd_addr[AW-1:0]] : 8'h00;

endmodule

// File: rtl/wwn_walker.sv
module wwn_walker
    import wwn_scan_pkg::*;
#(
    parameter int DEPTH     = 128,
    parameter int WWN_BYTES = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(WWN_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          rd_ok,
    input  logic [7:0]    rd_data,
    output ptr_t          rd_addr,
    output logic          busy,
    output logic          done,
    output logic          cap_clear,
    output logic          cap_shift,
    output logic          cap_commit,
    output logic [AW-1:0] cap_offset
);
    localparam ptr_t LIMIT     = ptr_t'(DEPTH);
    localparam ptr_t HDR       = ptr_t'(HDR_BYTES);
    localparam ptr_t LAST_BYTE = ptr_t'(HDR_BYTES + WWN_BYTES - 1);
    localparam ptr_t MARK_STEP = ptr_t'(6);

    walk_state_t state_q;
    ptr_t        ptr_q, tag_end_q, sub_q, sub_next_q;
    logic [7:0]  len_lo_q;
    logic [6:0]  tag_name_q;
    logic [5:0]  sub_name_q;
    logic [CW-1:0] cnt_q;
    logic        rd_req;
    logic        accept;
    tag_info_t   ti;

    assign ti     = decode_tag(rd_data);
    assign busy   = (state_q != WK_IDLE) && (state_q != WK_DONE);
    assign done   = (state_q == WK_DONE);
    assign accept = start && !busy;

    always_comb begin
        rd_addr = ptr_q;
        rd_req  = 1'b1;
        unique case (state_q)
            WK_TAG:     rd_addr = ptr_q;
            WK_LEN_LO:  rd_addr = ptr_q + ptr_t'(1);
            WK_LEN_HI:  rd_addr = ptr_q + ptr_t'(2);
            WK_MARK:    rd_addr = sub_q;
            WK_SUB: begin
                rd_addr = sub_q;
                rd_req  = (sub_q < tag_end_q);
            end
            WK_SLEN_LO: rd_addr = sub_q + ptr_t'(1);
            WK_SLEN_HI: rd_addr = sub_q + ptr_t'(2);
            WK_COPY:    rd_addr = sub_q + HDR + ptr_t'(cnt_q);
            default:    rd_req  = 1'b0;
        endcase
    end

    assign cap_clear  = accept;
    assign cap_shift  = (state_q == WK_COPY);
    assign cap_commit = (state_q == WK_COPY) && (cnt_q == CW'(WWN_BYTES - 1));
    assign cap_offset = AW'(sub_q + HDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= WK_IDLE;
            ptr_q      <= '0;
            tag_end_q  <= '0;
            sub_q      <= '0;
            sub_next_q <= '0;
            len_lo_q   <= '0;
            tag_name_q <= '0;
            sub_name_q <= '0;
            cnt_q      <= '0;
        end else begin
            unique case (state_q)
                WK_IDLE, WK_DONE: begin
                    if (start) begin
                        ptr_q   <= '0;
                        state_q <= WK_TAG;
                    end
                end
                WK_TAG: begin
                    if (!rd_ok) begin
                        state_q <= WK_DONE;
                    end else if (!ti.is_long) begin
                        if (ti.name[3:0] == SHORT_END_NAME) begin
                            state_q <= WK_DONE;
                        end else begin
                            ptr_q <= ptr_q + ptr_t'(ti.short_span);
                        end
                    end else begin
                        tag_name_q <= ti.name;
                        state_q    <= WK_LEN_LO;
                    end
                end
                WK_LEN_LO: begin
                    if (!rd_ok) begin
                        state_q <= WK_DONE;
                    end else begin
                        len_lo_q <= rd_data;
                        state_q  <= WK_LEN_HI;
                    end
                end
                WK_LEN_HI: begin
                    if (!rd_ok) begin
                        state_q <= WK_DONE;
                    end else begin
                        tag_end_q <= span_end(ptr_q, len_lo_q, rd_data);
                        if (tag_name_q == KEYLIST_NAME) begin
                            sub_q   <= ptr_q + HDR;
                            state_q <= WK_MARK;
                        end else begin
                            ptr_q   <= span_end(ptr_q, len_lo_q, rd_data);
                            state_q <= WK_TAG;
                        end
                    end
                end
                WK_MARK: begin
                    if (!rd_ok) begin
                        state_q <= WK_DONE;
                    end else if (rd_data == KEYLIST_MARKER) begin
                        ptr_q   <= ptr_q + MARK_STEP;
                        state_q <= WK_TAG;
                    end else begin
                        state_q <= WK_SUB;
                    end
                end
                WK_SUB: begin
                    if (sub_q >= tag_end_q) begin
                        ptr_q   <= tag_end_q;
                        state_q <= WK_TAG;
                    end else if (!rd_ok) begin
                        state_q <= WK_DONE;
                    end else begin
                        sub_name_q <= rd_data[5:0];
                        state_q    <= WK_SLEN_LO;
                    end
                end
                WK_SLEN_LO: begin
                    if (!rd_ok) begin
                        state_q <= WK_DONE;
                    end else begin
                        len_lo_q <= rd_data;
                        state_q  <= WK_SLEN_HI;
                    end
                end
                WK_SLEN_HI: begin
                    if (!rd_ok) begin
                        state_q <= WK_DONE;
                    end else if (sub_name_q == WWN_KEY_NAME) begin
                        sub_next_q <= span_end(sub_q, len_lo_q, rd_data);
                        if ((sub_q + LAST_BYTE) >= LIMIT) begin
                            state_q <= WK_DONE;
                        end else begin
                            cnt_q   <= '0;
                            state_q <= WK_COPY;
                        end
                    end else begin
                        sub_q   <= span_end(sub_q, len_lo_q, rd_data);
                        state_q <= WK_SUB;
                    end
                end
                WK_COPY: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == CW'(WWN_BYTES - 1)) begin
                        sub_q   <= sub_next_q;
                        state_q <= WK_SUB;
                    end
                end
                default: state_q <= WK_IDLE;
            endcase
        end
    end

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy && !done));

    // R1
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R7
    past_end_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ok && state_q != WK_COPY) |=> done);

    // R4
    sub_walk_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WK_SUB && sub_q >= tag_end_q) |=>
            (state_q == WK_TAG && ptr_q == $past(tag_end_q)));

    // R7
    copy_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WK_COPY) |-> rd_ok);

endmodule

// File: rtl/wwn_collector.sv
module wwn_collector #(
    parameter int DEPTH     = 128,
    parameter int WWN_BYTES = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int WW = 8 * WWN_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_clear,
    input  logic          cap_shift,
    input  logic          cap_commit,
    input  logic [AW-1:0] cap_offset,
    input  logic [7:0]    rd_data,
    output logic          found,
    output logic [AW-1:0] wwn_offset,
    output logic [WW-1:0] wwn
);
    logic [WW-1:0] acc_q;
    logic [WW-1:0] acc_next;

    assign acc_next = {acc_q[WW-9:0], rd_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            found      <= 1'b0;
            wwn_offset <= '0;
            wwn        <= '0;
        end else if (cap_clear) begin
            acc_q      <= '0;
            found      <= 1'b0;
            wwn_offset <= '0;
            wwn        <= '0;
        end else if (cap_shift) begin
            acc_q <= acc_next;
            if (cap_commit) begin
                wwn        <= acc_next;
                wwn_offset <= cap_offset;
                found      <= 1'b1;
            end
        end
    end

    // R6
    found_fit_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> ((int'(wwn_offset) + WWN_BYTES <= DEPTH) && (wwn_offset != '0)));

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cap_clear |=> (!found && wwn_offset == '0 && wwn == '0));

    // R9
    commit_update_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_commit && !cap_clear) |=> (found && wwn_offset == $past(cap_offset)));

endmodule

// File: rtl/wwn_tag_scanner.sv
module wwn_tag_scanner
    import wwn_scan_pkg::*;
#(
    parameter int IMG_BYTES = 128,
    parameter int WWN_BYTES = 8,
    localparam int AW = $clog2(IMG_BYTES),
    localparam int WW = 8 * WWN_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          found,
    output logic [AW-1:0] wwn_offset,
    output logic [WW-1:0] wwn
);
    ptr_t          rd_addr;
    logic          rd_ok;
    logic [7:0]    rd_data;
    logic          cap_clear, cap_shift, cap_commit;
    logic [AW-1:0] cap_offset;
    logic          store_en;

    assign store_en = wr_en && !busy;

    vpd_image_store #(.DEPTH(IMG_BYTES)) u_store (
        .clk     (clk),
        .wr_en   (store_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_ok   (rd_ok),
        .rd_data (rd_data)
    );

    wwn_walker #(.DEPTH(IMG_BYTES), .WWN_BYTES(WWN_BYTES)) u_walker (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .rd_ok      (rd_ok),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .busy       (busy),
        .done       (done),
        .cap_clear  (cap_clear),
        .cap_shift  (cap_shift),
        .cap_commit (cap_commit),
        .cap_offset (cap_offset)
    );

    wwn_collector #(.DEPTH(IMG_BYTES), .WWN_BYTES(WWN_BYTES)) u_collect (
        .clk        (clk),
        .rst        (rst),
        .cap_clear  (cap_clear),
        .cap_shift  (cap_shift),
        .cap_commit (cap_commit),
        .cap_offset (cap_offset),
        .rd_data    (rd_data),
        .found      (found),
        .wwn_offset (wwn_offset),
        .wwn        (wwn)
    );

    // R10
    no_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |-> !store_en);

endmodule

// File: tb/test_wwn_tag_scanner.sv
module test_wwn_tag_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int N = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        start = 1'b0;
    logic        busy, done, found;
    logic [6:0]  wwn_offset;
    logic [63:0] wwn;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] img [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    wwn_tag_scanner i_wwn_tag_scanner (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .busy(busy), .done(done),
        .found(found), .wwn_offset(wwn_offset), .wwn(wwn)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent walk of the image per the requirements.
    task automatic model(output bit f, output int off, output logic [63:0] w);
        int i, j, e, len, sl;
        bit stop;
        logic [7:0] z;
        f = 0; off = 0; w = '0; i = 0; stop = 0;
        while (i < N && !stop) begin
            z = img[i];
            if (!z[7]) begin
                if (z[6:3] == 4'hF) stop = 1;
                else i += 1 + int'(z[2:0]);
            end else if (i + 2 > N - 1) begin
                stop = 1;
            end else begin
                len = 3 + int'(img[i+1]) + 256 * int'(img[i+2]);
                if (z[6:0] == 7'h0D) begin
                    j = i + 3;
                    if (j > N - 1) stop = 1;
                    else if (img[j] == 8'h3B) i += 6;
                    else begin
                        e = i + len;
                        while (j < e && !stop) begin
                            if (j + 2 > N - 1) stop = 1;
                            else begin
                                sl = int'(img[j+1]) + 256 * int'(img[j+2]);
                                if (img[j][5:0] == 6'h3C) begin
                                    if (j + 10 > N - 1) stop = 1;
                                    else begin
                                        f = 1; off = j + 3;
                                        for (int k = 0; k < 8; k++) w = {w[55:0], img[j+3+k]};
                                    end
                                end
                                j += sl + 3;
                            end
                        end
                        i = e;
                    end
                end else begin
                    i += len;
                end
            end
        end
    endtask

    task automatic load_all();
        for (int a = 0; a < N; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 7'(a); wr_data = img[a];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic scan(input string req);
        int guard;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && done === 1'b0, "R1 busy after start", {62'd0, busy, done}, 64'd2);
        guard = 0;
        while (done !== 1'b1 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(done === 1'b1 && busy === 1'b0, req, {62'd0, busy, done}, 64'd1);
    endtask

    task automatic scan_and_compare(input string req);
        bit ef; int eo; logic [63:0] ew;
        model(ef, eo, ew);
        scan(req);
        chk(found === ef, req, {63'd0, found}, {63'd0, ef});
        chk(wwn_offset === 7'(eo), req, {57'd0, wwn_offset}, 64'(eo));
        chk(wwn === ew, req, wwn, ew);
    endtask

    task automatic fill(input logic [7:0] v);
        for (int a = 0; a < N; a++) img[a] = v;
    endtask

    task automatic setb(input int a, input logic [7:0] v);
        if (a < N && a >= 0) img[a] = v;
    endtask

    // Keyword tag with a single WWN sub-field at position p; WWN at p+6.
    task automatic put_wwn_tag(input int p, input logic [63:0] v);
        setb(p, 8'h8D); setb(p+1, 8'd11); setb(p+2, 8'd0);
        setb(p+3, 8'h3C); setb(p+4, 8'd8); setb(p+5, 8'd0);
        for (int k = 0; k < 8; k++) setb(p+6+k, v[63-8*k -: 8]);
    endtask

    task automatic build_random();
        int pos, kind, l, p, ns, nm;
        for (int a = 0; a < N; a++) img[a] = 8'($urandom);
        pos = 0;
        while (pos < 120) begin
            kind = $urandom % 6;
            case (kind)
                0: begin
                    nm = $urandom % 15; l = $urandom % 8;
                    setb(pos, {1'b0, 4'(nm), 3'(l)}); pos += 1 + l;
                end
                1: begin
                    nm = $urandom % 128; if (nm == 13) nm = 14;
                    l = $urandom % 6;
                    setb(pos, 8'h80 | 8'(nm)); setb(pos+1, 8'(l)); setb(pos+2, 8'd0);
                    pos += 3 + l;
                end
                2, 3: begin
                    p = pos + 3; ns = $urandom % 4;
                    for (int s = 0; s < ns; s++) begin
                        if ($urandom % 2 == 0) begin
                            setb(p, {2'($urandom), 6'h3C}); setb(p+1, 8'd8); setb(p+2, 8'd0);
                            p += 11;
                        end else begin
                            l = $urandom % 5; nm = $urandom % 64; if (nm == 60) nm = 1;
                            setb(p, {2'($urandom), 6'(nm)}); setb(p+1, 8'(l)); setb(p+2, 8'd0);
                            p += 3 + l;
                        end
                    end
                    if (ns == 0) setb(pos+3, 8'h00);
                    setb(pos, 8'h8D); setb(pos+1, 8'(p - pos - 3)); setb(pos+2, 8'd0);
                    pos = p;
                end
                4: begin
                    setb(pos, 8'h8D); setb(pos+1, 8'($urandom)); setb(pos+2, 8'd0);
                    setb(pos+3, 8'h3B); pos += 6;
                end
                default: begin
                    if ($urandom % 3 == 0) setb(pos, 8'h78 | 8'($urandom % 8));
                    pos += 1;
                end
            endcase
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h1234_5EED);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 0 && done === 0 && found === 0 && wwn_offset === 0 && wwn === 0,
            "R1 reset state", {busy, done, found, wwn_offset, 54'd0}, 64'd0);

        // R6 R11 bare keyword tag with WWN at offset 6, then end tag
        fill(8'h00); put_wwn_tag(0, 64'h1122_3344_5566_7788); setb(14, 8'h78);
        load_all(); scan_and_compare("R6 basic WWN");
        chk(wwn_offset === 7'd6 && wwn === 64'h1122_3344_5566_7788, "R6 direct value",
            wwn, 64'h1122_3344_5566_7788);

        // R2 short tags first: span 2 then span 8, keyword tag at 10
        fill(8'h00); setb(0, 8'h09); setb(2, 8'h17); put_wwn_tag(10, 64'hA1B2_C3D4_E5F6_0718);
        load_all(); scan_and_compare("R2 short tag steps");
        chk(wwn_offset === 7'd16, "R2 offset after short tags", {57'd0, wwn_offset}, 64'd16);

        // R2 end tag ahead of a valid WWN
        fill(8'h00); setb(0, 8'h7A); put_wwn_tag(3, 64'hDEAD_BEEF_0000_0001);
        load_all(); scan_and_compare("R2 end tag stops");
        chk(found === 1'b0, "R2 nothing past end tag", {63'd0, found}, 64'd0);

        // R5 marker: declared span 0x23 would skip the WWN at 6
        fill(8'h00); setb(0, 8'h8D); setb(1, 8'h20); setb(2, 8'h00); setb(3, 8'h3B);
        put_wwn_tag(6, 64'h0102_0304_0506_0708);
        load_all(); scan_and_compare("R5 marker step");
        chk(found === 1'b1 && wwn_offset === 7'd12, "R5 marker lands on WWN",
            {57'd0, wwn_offset}, 64'd12);

        // R3 foreign long tag whose body mimics a keyword tag
        fill(8'h00); setb(0, 8'h90); setb(1, 8'd14); setb(2, 8'd0);
        put_wwn_tag(3, 64'hFFFF_0000_FFFF_0000);
        put_wwn_tag(17, 64'h5A5A_A5A5_3C3C_C3C3);
        load_all(); scan_and_compare("R3 foreign tag skipped");
        chk(wwn_offset === 7'd23, "R3 only outer WWN seen", {57'd0, wwn_offset}, 64'd23);

        // R7 WWN in the last fitting slot (bytes 120..127)
        fill(8'h00); setb(0, 8'h90); setb(1, 8'd111); setb(2, 8'd0);
        put_wwn_tag(114, 64'hCAFE_F00D_1234_5678);
        load_all(); scan_and_compare("R7 last fitting WWN");
        chk(found === 1'b1 && wwn_offset === 7'd120, "R7 fits at 120", {57'd0, wwn_offset}, 64'd120);

        // R7 one byte later: would run past the image
        fill(8'h00); setb(0, 8'h90); setb(1, 8'd112); setb(2, 8'd0);
        put_wwn_tag(115, 64'hCAFE_F00D_1234_5678);
        load_all(); scan_and_compare("R7 overflowing WWN dropped");
        chk(found === 1'b0 && wwn_offset === 7'd0, "R7 R8 not captured", {63'd0, found}, 64'd0);

        // R7 R8 all-zero image walks to the end
        fill(8'h00); load_all(); scan_and_compare("R8 empty image");

        // R4 R9 two sub-fields in one keyword tag, later wins
        fill(8'h00); setb(0, 8'h8D); setb(1, 8'd25); setb(2, 8'd0);
        setb(3, 8'h05); setb(4, 8'd0); setb(5, 8'd0);
        setb(6, 8'hFC); setb(7, 8'd8); setb(8, 8'd0);
        for (int k = 0; k < 8; k++) setb(9+k, 8'h10 + 8'(k));
        setb(17, 8'h3C); setb(18, 8'd8); setb(19, 8'd0);
        for (int k = 0; k < 8; k++) setb(20+k, 8'h80 + 8'(k));
        setb(28, 8'h78);
        load_all(); scan_and_compare("R9 last match wins");
        chk(wwn_offset === 7'd20 && wwn === 64'h8081_8283_8485_8687, "R9 second WWN",
            wwn, 64'h8081_8283_8485_8687);

        // R10 write while busy is dropped; rescan shows the image unchanged
        fill(8'h00); put_wwn_tag(0, 64'h1122_3344_5566_7788); setb(14, 8'h78);
        load_all();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wr_en = 1'b1; wr_addr = 7'd6; wr_data = 8'hEE;
        @(negedge clk); wr_en = 1'b0;
        while (done !== 1'b1) @(negedge clk);
        chk(wwn === 64'h1122_3344_5566_7788, "R10 busy write ignored", wwn, 64'h1122_3344_5566_7788);
        scan_and_compare("R10 rescan unchanged");

        // R11 idle write takes effect
        @(negedge clk); wr_en = 1'b1; wr_addr = 7'd6; wr_data = 8'hEE;
        @(negedge clk); wr_en = 1'b0;
        img[6] = 8'hEE;
        scan_and_compare("R11 idle write");
        chk(wwn[63:56] === 8'hEE, "R11 new first byte", {56'd0, wwn[63:56]}, 64'hEE);

        // R4 random structured images
        for (int n = 0; n < 60; n++) begin
            build_random();
            load_all();
            scan_and_compare("R4 random image");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule